// File: doc/BRIEF.md
# Exception Stack Frame Push Sequencer

This block turns one interrupt or exception entry into the ordered series of stack writes that save the interrupted context. A handler has already been chosen when the block starts. A one-cycle `start` pulse captures everything the frame needs: the vector number, the kind of event, whether the privilege level changes, the gate size, the saved state (stack selector, stack pointer, flags, code selector, and two candidate return addresses) and the fields that make up the error code. The block then presents one write at a time on a valid/ready port. Each write carries an address, data and a width flag. The block moves the stack pointer down before every write, and when the last write has been accepted it reports the final stack pointer with a one-cycle `done` pulse.

The frame layout depends on the entry. When privilege does not change, the frame goes onto the interrupted stack. When privilege changes, it goes onto the new stack, starting with the interrupted stack selector and stack pointer. An error code is appended only for a small fixed set of exception vectors, and only when the event is a processor exception. The block chooses between the address of the faulting instruction and the address of the next instruction, according to how the event resumes.

Top module: `exc_frame_pusher`

## Requirements
- R1: After reset, and whenever reset is asserted during a frame, `wr_valid` and `done` are low.
- R2: With `priv_change`=0, the writes are flags, code selector, return address, then the error code if one applies, starting below `old_esp`.
- R3: With `priv_change`=1, the writes start with `old_ss` and then `old_esp`, starting below `new_esp`, followed by the same tail as R2.
- R4: An error code is written only when `src_kind`=0 (processor exception) and the vector is 8, 10, 11, 12, 13, 14 or 17. With `src_kind`=1 (external pin) or 2 or 3 (software interrupt), no error code is written for any vector.
- R5: The error code is {16'b0, err_index[12:0], err_ti, err_idt, err_ext}, so bit 0 is the external flag, bit 1 the table flag, bit 2 the local-table flag and bits 15:3 the index. For vector 8 the error code is zero.
- R6: With `gate32`=1, each write is 4 bytes with `wr_dword`=1. With `gate32`=0, each write is 2 bytes with `wr_dword`=0 and bits 31:16 of `wr_data` zero. `wr_addr` is the pointer after it has been decremented by the write size. Selector values are zero-extended.
- R7: The return address is `cur_eip` for exceptions other than vectors 1, 3 and 4. It is `next_eip` for those three vectors and for all external or software events.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_data` and `wr_dword` stay stable.
- R9: `done` pulses for exactly one cycle, in the cycle after the last write is accepted. At that point `final_esp` equals the address of the last write.
- R10: A `start` pulse is ignored while a frame is in progress, so the current frame continues unchanged.
- R11: The first write is valid in the cycle after `start` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (sampled only when idle) |
| vector | input | 8 | Interrupt vector number |
| src_kind | input | 2 | 0 exception, 1 external pin, 2/3 software interrupt |
| priv_change | input | 1 | Entry switches to a new stack |
| gate32 | input | 1 | 1 = 32-bit gate, 0 = 16-bit gate |
| old_ss | input | 16 | Interrupted stack selector |
| old_esp | input | 32 | Interrupted stack pointer |
| new_esp | input | 32 | Stack pointer of the handler stack on privilege change |
| eflags | input | 32 | Saved flags |
| old_cs | input | 16 | Interrupted code selector |
| cur_eip | input | 32 | Address of the current instruction |
| next_eip | input | 32 | Address of the following instruction |
| err_ext | input | 1 | Error-code external-event flag |
| err_idt | input | 1 | Error-code interrupt-table flag |
| err_ti | input | 1 | Error-code local-table flag |
| err_index | input | 13 | Error-code selector index |
| wr_valid | output | 1 | Write request present |
| wr_ready | input | 1 | Write accepted when high with `wr_valid` |
| wr_addr | output | 32 | Write address (decremented pointer) |
| wr_data | output | 32 | Write data |
| wr_dword | output | 1 | 1 = 4-byte write, 0 = 2-byte write |
| done | output | 1 | One-cycle end-of-frame pulse |
| final_esp | output | 32 | Stack pointer after the frame |

## Verification
The first write is due one clock after `start`. Each later write appears one clock after the previous one is accepted, and `done` appears one clock after the last acceptance. The bench therefore drives at the falling edge and reads at the next falling edge, which follows exactly one rising edge. During a stall it waits two extra cycles and expects unchanged outputs. For every frame it counts the writes it expects from its own model of the layout, so `done` arriving early or late shows up as a missing or extra error-code write.

// File: rtl/exc_frame_pusher.sv
module exc_frame_pusher (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  vector,
  input  logic [1:0]  src_kind,
  input  logic        priv_change,
  input  logic        gate32,
  input  logic [15:0] old_ss,
  input  logic [31:0] old_esp,
  input  logic [31:0] new_esp,
  input  logic [31:0] eflags,
  input  logic [15:0] old_cs,
  input  logic [31:0] cur_eip,
  input  logic [31:0] next_eip,
  input  logic        err_ext,
  input  logic        err_idt,
  input  logic        err_ti,
  input  logic [12:0] err_index,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  output logic        wr_dword,
  output logic        done,
  output logic [31:0] final_esp
);
  localparam logic [2:0] ST_SS  = 3'd0;
  localparam logic [2:0] ST_ESP = 3'd1;
  localparam logic [2:0] ST_FL  = 3'd2;
  localparam logic [2:0] ST_CS  = 3'd3;
  localparam logic [2:0] ST_IP  = 3'd4;
  localparam logic [2:0] ST_ERR = 3'd5;

  logic [2:0]  stage;
  logic [31:0] sp;
  logic [15:0] l_ss, l_cs;
  logic [31:0] l_esp, l_fl, l_ip, l_err;
  logic        l_has_err, l_d32;

  logic        has_err, resume_next, last, take;
  logic [31:0] err_word, raw, base, step_in, step;

  always_comb begin
    case (vector)
      8'd8, 8'd10, 8'd11, 8'd12, 8'd13, 8'd14, 8'd17: has_err = (src_kind == 2'd0);
      default: has_err = 1'b0;
    endcase
  end

  assign resume_next = (src_kind != 2'd0) || vector == 8'd1 || vector == 8'd3 || vector == 8'd4;
  assign err_word    = (vector == 8'd8) ? 32'd0 : {16'd0, err_index, err_ti, err_idt, err_ext};
  assign base        = priv_change ? new_esp : old_esp;
  assign step_in     = gate32 ? 32'd4 : 32'd2;
  assign step        = l_d32 ? 32'd4 : 32'd2;
  assign take        = wr_valid && wr_ready;
  assign last        = (stage == ST_ERR) || (stage == ST_IP && !l_has_err);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid  <= 1'b0;
      done      <= 1'b0;
      stage     <= ST_FL;
      sp        <= 32'd0;
      final_esp <= 32'd0;
      l_ss <= 16'd0; l_cs <= 16'd0;
      l_esp <= 32'd0; l_fl <= 32'd0; l_ip <= 32'd0; l_err <= 32'd0;
      l_has_err <= 1'b0; l_d32 <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!wr_valid) begin
        if (start) begin
          wr_valid  <= 1'b1;
          stage     <= priv_change ? ST_SS : ST_FL;
          sp        <= base - step_in;
          l_ss      <= old_ss;
          l_cs      <= old_cs;
          l_esp     <= old_esp;
          l_fl      <= eflags;
          l_ip      <= resume_next ? next_eip : cur_eip;
          l_err     <= err_word;
          l_has_err <= has_err;
          l_d32     <= gate32;
        end
      end else if (take) begin
        if (last) begin
          wr_valid  <= 1'b0;
          done      <= 1'b1;
          final_esp <= sp;
        end else begin
          stage <= stage + 3'd1;
          sp    <= sp - step;
        end
      end
    end
  end

  always_comb begin
    case (stage)
      ST_SS:   raw = {16'd0, l_ss};
      ST_ESP:  raw = l_esp;
      ST_FL:   raw = l_fl;
      ST_CS:   raw = {16'd0, l_cs};
      ST_IP:   raw = l_ip;
      default: raw = l_err;
    endcase
  end

  assign wr_addr  = sp;
  assign wr_data  = l_d32 ? raw : {16'd0, raw[15:0]};
  assign wr_dword = l_d32;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_dword)));

  // R6
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!wr_valid || wr_addr == $past(wr_addr) - ($past(wr_dword) ? 32'd4 : 32'd2)));

  // R9
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_valid && wr_ready) && !wr_valid && final_esp == $past(wr_addr)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  narrow_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_dword) |-> (wr_data[31:16] == 16'd0));
endmodule

// File: tb/exc_frame_pusher_tb.sv
module exc_frame_pusher_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, priv_change, gate32, err_ext, err_idt, err_ti, wr_ready;
  logic [7:0]  vector;
  logic [1:0]  src_kind;
  logic [15:0] old_ss, old_cs;
  logic [31:0] old_esp, new_esp, eflags, cur_eip, next_eip;
  logic [12:0] err_index;
  logic        wr_valid, wr_dword, done;
  logic [31:0] wr_addr, wr_data, final_esp;

  exc_frame_pusher u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vector(vector), .src_kind(src_kind),
    .priv_change(priv_change), .gate32(gate32), .old_ss(old_ss), .old_esp(old_esp),
    .new_esp(new_esp), .eflags(eflags), .old_cs(old_cs), .cur_eip(cur_eip),
    .next_eip(next_eip), .err_ext(err_ext), .err_idt(err_idt), .err_ti(err_ti),
    .err_index(err_index), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_dword(wr_dword), .done(done), .final_esp(final_esp));

  // fields: vector, src_kind, priv, gate32, ext, idt, ti, index
  localparam logic [27:0] CASES [12] = '{
    {8'd13,  2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 13'd5},
    {8'd14,  2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 13'h1FFF},
    {8'd8,   2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 13'd7},
    {8'd13,  2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 13'd9},
    {8'd14,  2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 13'd4},
    {8'd3,   2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 13'd0},
    {8'd0,   2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 13'd0},
    {8'd2,   2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 13'd0},
    {8'd200, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 13'd2},
    {8'd17,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 13'd3},
    {8'd10,  2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 13'd6},
    {8'd11,  2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 13'd1}
  };

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] exp_a [6];
  logic [31:0] exp_d [6];
  string       exp_t [6];
  int          exp_n;
  logic        exp_w;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic add_push(input logic [31:0] v, input bit w32, input string tag,
                          inout logic [31:0] sp);
    sp = sp - (w32 ? 32'd4 : 32'd2);
    exp_a[exp_n] = sp;
    exp_d[exp_n] = w32 ? v : {16'd0, v[15:0]};
    exp_t[exp_n] = tag;
    exp_n++;
  endtask

  task automatic build(input logic [27:0] c);
    logic [7:0]  v  = c[27:20];
    logic [1:0]  k  = c[19:18];
    bit          pc = c[17];
    bit          w  = c[16];
    logic [31:0] sp = pc ? new_esp : old_esp;
    bit          errv;
    logic [31:0] ec;
    exp_n = 0;
    exp_w = w;
    errv = (k == 2'd0) && (v == 8'd8 || v == 8'd10 || v == 8'd11 || v == 8'd12 ||
                           v == 8'd13 || v == 8'd14 || v == 8'd17);
    ec = (v == 8'd8) ? 32'd0 : {16'd0, c[12:0], c[13], c[14], c[15]};
    if (pc) begin
      add_push({16'd0, old_ss}, w, "R3", sp);
      add_push(old_esp, w, "R3", sp);
    end
    add_push(eflags, w, "R2", sp);
    add_push({16'd0, old_cs}, w, "R2", sp);
    add_push(((k != 2'd0) || v == 8'd1 || v == 8'd3 || v == 8'd4) ? next_eip : cur_eip, w, "R7", sp);
    if (errv) add_push(ec, w, "R5", sp);
  endtask

  task automatic apply(input logic [27:0] c);
    vector = c[27:20]; src_kind = c[19:18]; priv_change = c[17]; gate32 = c[16];
    err_ext = c[15]; err_idt = c[14]; err_ti = c[13]; err_index = c[12:0];
  endtask

  task automatic run_case(input logic [27:0] c, input bit stall, input bit restart);
    build(c);
    @(negedge clk);
    apply(c);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < exp_n; i++) begin
      chk(wr_valid === 1'b1, (i == 0) ? "R11" : exp_t[i], "wr_valid", {31'd0, wr_valid}, 32'd1);
      chk(wr_addr === exp_a[i], exp_t[i], "wr_addr R6", wr_addr, exp_a[i]);
      chk(wr_data === exp_d[i], exp_t[i], "wr_data R6", wr_data, exp_d[i]);
      chk(wr_dword === exp_w, "R6", "wr_dword", {31'd0, wr_dword}, {31'd0, exp_w});
      chk(done === 1'b0, "R9", "early done", {31'd0, done}, 32'd0);
      if (stall && i == 1) begin
        wr_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(wr_valid === 1'b1 && wr_addr === exp_a[i] && wr_data === exp_d[i],
            "R8", "stalled write", wr_data, exp_d[i]);
        wr_ready = 1'b1;
      end
      if (restart && i == 1) begin
        vector = 8'd13; src_kind = 2'd0; priv_change = ~c[17]; gate32 = ~c[16];
        start = 1'b1;
      end
      @(negedge clk);
      if (restart && i == 1) begin
        start = 1'b0;
        apply(c);
      end
    end
    chk(done === 1'b1, "R4", "done after expected writes (R9)", {31'd0, done}, 32'd1);
    chk(wr_valid === 1'b0, "R9", "valid after frame", {31'd0, wr_valid}, 32'd0);
    chk(final_esp === exp_a[exp_n-1], "R9", "final_esp", final_esp, exp_a[exp_n-1]);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done width", {31'd0, done}, 32'd0);
    if (restart)
      chk(wr_valid === 1'b0, "R10", "ignored start began a frame", {31'd0, wr_valid}, 32'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; wr_ready = 1'b1;
    old_ss = 16'hFF23; old_cs = 16'h8008;
    old_esp = 32'h0000_8000; new_esp = 32'h0001_0000;
    eflags = 32'hA5C3_0202; cur_eip = 32'h1234_1000; next_eip = 32'h1234_1003;
    apply(CASES[0]);
    repeat (3) @(negedge clk);
    chk(wr_valid === 1'b0 && done === 1'b0, "R1", "reset outputs",
        {30'd0, wr_valid, done}, 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < 12; k++) run_case(CASES[k], k == 4 || k == 9, 1'b0);

    run_case(CASES[1], 1'b0, 1'b1);
    run_case(CASES[10], 1'b1, 1'b1);

    @(negedge clk);
    apply(CASES[1]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wr_ready = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(wr_valid === 1'b0 && done === 1'b0, "R1", "reset mid-frame",
        {30'd0, wr_valid, done}, 32'd0);
    rst_n = 1'b1;
    wr_ready = 1'b1;
    @(negedge clk);
    chk(wr_valid === 1'b0, "R1", "idle after reset", {31'd0, wr_valid}, 32'd0);

    run_case(CASES[2], 1'b1, 1'b0);
    summary();
  end
endmodule